// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two unsigned words one bit position per clock, using a single full-adder cell. Both operands sit in shift registers that load in parallel and shift toward the least significant end. On every shift cycle the cell adds the two low bits and the stored carry. The sum bit enters the top of the first operand register, and the new carry is kept in a flip-flop. After as many shift cycles as the word has bits, the first operand register holds the sum, the carry flip-flop holds the carry out of the top bit, and a done flag rises.

While the first operand shifts, the second operand register takes a bit from a serial input at its top end. A re-arm control clears the bit counter and the carry and leaves both registers as they are. A second pass then adds the serially gathered word to the previous sum, so the block can accumulate values that arrive one bit at a time.

Top module: `serial_adder`

## Requirements
- R1: While reset is asserted and right after it is released, `acc_q` is 0, `carry_q` is 0 and `done_q` is 0.
- R2: A cycle with `load_en` high copies `opa_in` into the A register and `opb_in` into the B register. From the next cycle `carry_q` is 0 and `done_q` is 0.
- R3: A shift cycle happens when `run_en` is high, `load_en` and `rearm_en` are low, and `done_q` is low. In it, A shifts right by one. The sum of A bit 0, B bit 0 and the carry enters A at bit WIDTH-1, and the carry-out of that addition becomes the new `carry_q`.
- R4: After exactly WIDTH shift cycles following a load, `done_q` is 1. At that point `acc_q` equals (A+B) mod 2^WIDTH and `carry_q` equals bit WIDTH of A+B. After fewer than WIDTH shift cycles, `done_q` is 0.
- R5: While `done_q` is 1, `run_en` has no effect: `acc_q`, `carry_q` and `done_q` do not change.
- R6: A cycle with `run_en`, `load_en` and `rearm_en` all low changes neither `acc_q` nor `carry_q`. Idle cycles placed between shift cycles leave the final sum unchanged.
- R7: In each shift cycle, `b_ser_in` enters the B register at bit WIDTH-1 as B shifts right. After WIDTH shifts, bit i of B is the serial bit given in shift cycle i, counting from 0.
- R8: A cycle with `rearm_en` high and `load_en` low keeps A and B. From the next cycle `carry_q` and `done_q` are 0, and a further WIDTH shift cycles are allowed.
- R9: `load_en` takes priority over `rearm_en`, and `rearm_en` takes priority over a shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Parallel load of both operands |
| rearm_en | input | 1 | Clear bit counter and carry, keep registers |
| run_en | input | 1 | Permit a shift cycle |
| opa_in | input | WIDTH | Parallel value for the A register |
| opb_in | input | WIDTH | Parallel value for the B register |
| b_ser_in | input | 1 | Serial bit entering the top of B |
| acc_q | output | WIDTH | A register contents |
| carry_q | output | 1 | Carry flip-flop |
| done_q | output | 1 | WIDTH shift cycles completed |

## Verification
The bench builds the block with its default WIDTH of 4. At that width every one of the 256 operand pairs can be added in full, so each carry pattern through the single cell is covered, including the all-ones cases that carry out of the top bit. The small width also keeps a per-cycle trace with idle gaps short, which lets the bench follow the done flag from one cycle to the next. It also keeps a two-pass accumulation short, and that pass shows the serially gathered B word through the sum.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_REARM = 2'd2,
    ACT_SHIFT = 2'd3
  } sadd_act_e;

  // Control priority: parallel load, then re-arm, then a shift if not finished.
  function automatic sadd_act_e pick_act(input logic ld, input logic rearm,
                                         input logic run, input logic fin);
    if (ld)              return ACT_LOAD;
    else if (rearm)      return ACT_REARM;
    else if (run && !fin) return ACT_SHIFT;
    else                 return ACT_HOLD;
  endfunction
endpackage

// File: rtl/sadd_shreg.sv
module sadd_shreg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         sh,
  input  logic [W-1:0] par_in,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic [W-1:0] shifted;

  generate
    if (W > 1) begin : g_wide
      assign shifted = {ser_in, q[W-1:1]};
    end else begin : g_one
      assign shifted = ser_in;
    end
  endgenerate

  always_comb begin
    q_d = q;
    if (ld)      q_d = par_in;
    else if (sh) q_d = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/sadd_fa.sv
module sadd_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = x ^ y ^ ci;
    co = (x & y) | (ci & (x ^ y));
  end
endmodule

// File: rtl/sadd_seq.sv
module sadd_seq
  import sadd_pkg::*;
#(
  parameter int W = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_en,
  input  logic      rearm_en,
  input  logic      run_en,
  output sadd_act_e act,
  output logic      fin
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign fin = (cnt_q == LAST);

  always_comb begin
    act   = pick_act(load_en, rearm_en, run_en, fin);
    cnt_d = cnt_q;
    case (act)
      ACT_LOAD, ACT_REARM: cnt_d = '0;
      ACT_SHIFT:           cnt_d = cnt_q + 1'b1;
      default:             cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/serial_adder.sv
module serial_adder
  import sadd_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             rearm_en,
  input  logic             run_en,
  input  logic [WIDTH-1:0] opa_in,
  input  logic [WIDTH-1:0] opb_in,
  input  logic             b_ser_in,
  output logic [WIDTH-1:0] acc_q,
  output logic             carry_q,
  output logic             done_q
);
  sadd_act_e    act;
  logic         fin;
  logic [WIDTH-1:0] b_q;
  logic         sum_bit;
  logic         cout;
  logic         carry_d;
  logic         do_load;
  logic         do_shift;

  assign do_load  = (act == ACT_LOAD);
  assign do_shift = (act == ACT_SHIFT);
  assign done_q   = fin;

  sadd_seq #(.W(WIDTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .rearm_en(rearm_en),
    .run_en(run_en), .act(act), .fin(fin)
  );

  sadd_fa u_fa (
    .x(acc_q[0]), .y(b_q[0]), .ci(carry_q), .s(sum_bit), .co(cout)
  );

  sadd_shreg #(.W(WIDTH)) u_areg (
    .clk(clk), .rst_n(rst_n), .ld(do_load), .sh(do_shift),
    .par_in(opa_in), .ser_in(sum_bit), .q(acc_q)
  );

  sadd_shreg #(.W(WIDTH)) u_breg (
    .clk(clk), .rst_n(rst_n), .ld(do_load), .sh(do_shift),
    .par_in(opb_in), .ser_in(b_ser_in), .q(b_q)
  );

  always_comb begin
    case (act)
      ACT_LOAD, ACT_REARM: carry_d = 1'b0;
      ACT_SHIFT:           carry_d = cout;
      default:             carry_d = carry_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= carry_d;
  end
endmodule

// File: rtl/serial_adder_chk.sv
module serial_adder_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_en,
  input logic         rearm_en,
  input logic         run_en,
  input logic [W-1:0] opa_in,
  input logic [W-1:0] acc_q,
  input logic         carry_q,
  input logic         done_q
);
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (acc_q == $past(opa_in)) && !carry_q && !done_q);

  p_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_en && !load_en) |=> (acc_q == $past(acc_q)) && !carry_q && !done_q);

  p_done_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !load_en && !rearm_en) |=> $stable(acc_q) && $stable(carry_q) && done_q);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !rearm_en && !run_en) |=> $stable(acc_q) && $stable(carry_q) && $stable(done_q));

  generate
    if (W > 1) begin : g_shift_chk
      p_shift_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !load_en && !rearm_en && !done_q) |=> acc_q[W-2:0] == $past(acc_q[W-1:1]));
    end
  endgenerate
endmodule

bind serial_adder serial_adder_chk #(.W(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_en(load_en), .rearm_en(rearm_en),
  .run_en(run_en), .opa_in(opa_in), .acc_q(acc_q), .carry_q(carry_q),
  .done_q(done_q)
);

// File: tb/serial_adder_test.sv
`timescale 1ns/1ps
module serial_adder_test;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         load_en, rearm_en, run_en, b_ser_in;
  logic [W-1:0] opa_in, opb_in;
  logic [W-1:0] acc_q;
  logic         carry_q, done_q;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  serial_adder #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .rearm_en(rearm_en),
    .run_en(run_en), .opa_in(opa_in), .opb_in(opb_in), .b_ser_in(b_ser_in),
    .acc_q(acc_q), .carry_q(carry_q), .done_q(done_q)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, return at the next falling edge.
  task automatic cyc(input logic ld, input logic ra, input logic rn, input logic sb);
    load_en = ld; rearm_en = ra; run_en = rn; b_ser_in = sb;
    @(posedge clk);
    @(negedge clk);
    load_en = 0; rearm_en = 0; run_en = 0; b_ser_in = 0;
  endtask

  task automatic load_ops(input int a, input int b);
    opa_in = W'(a); opb_in = W'(b);
    cyc(1, 0, 0, 0);
  endtask

  task automatic t_reset;
    rst_n = 0; load_en = 0; rearm_en = 0; run_en = 0; b_ser_in = 0;
    opa_in = '0; opb_in = '0;
    repeat (2) @(negedge clk);
    chk("R1 acc in reset", int'(acc_q), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 acc", int'(acc_q), 0);
    chk("R1 carry", int'(carry_q), 0);
    chk("R1 done", int'(done_q), 0);
  endtask

  task automatic t_exhaustive;
    for (int a = 0; a < M; a++) begin
      for (int b = 0; b < M; b++) begin
        load_ops(a, b);
        if (a == 3 && b == 9) begin
          chk("R2 acc after load", int'(acc_q), a);
          chk("R2 carry after load", int'(carry_q), 0);
        end
        for (int k = 0; k < W; k++) begin
          if (a == 3 && b == 9) chk("R4 done early", int'(done_q), 0);
          cyc(0, 0, 1, 0);
        end
        chk("R4 sum", int'(acc_q), (a + b) % M);
        chk("R4 carry", int'(carry_q), (a + b) / M);
        chk("R4 done", int'(done_q), 1);
      end
    end
  endtask

  task automatic t_gaps;
    // 7 + 5 = 12: first shift gives sum bit 0, carry 1, A = 0111>>1 = 0011
    load_ops(7, 5);
    cyc(0, 0, 1, 0);
    chk("R3 first shift acc", int'(acc_q), 3);
    chk("R3 first shift carry", int'(carry_q), 1);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    chk("R6 idle acc", int'(acc_q), 3);
    chk("R6 idle carry", int'(carry_q), 1);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 1, 0);
    chk("R4 done after three", int'(done_q), 0);
    cyc(0, 0, 1, 0);
    chk("R6 gapped sum", int'(acc_q), 12);
    chk("R6 gapped carry", int'(carry_q), 0);
    chk("R6 gapped done", int'(done_q), 1);
  endtask

  task automatic t_freeze;
    load_ops(15, 1);
    for (int k = 0; k < W; k++) cyc(0, 0, 1, 0);
    for (int k = 0; k < 3; k++) cyc(0, 0, 1, 1);
    chk("R5 acc frozen", int'(acc_q), 0);
    chk("R5 carry frozen", int'(carry_q), 1);
    chk("R5 done held", int'(done_q), 1);
  endtask

  task automatic t_serial;
    int s;
    s = 11;  // serial word 1011, fed bit 0 first
    load_ops(5, 6);
    for (int k = 0; k < W; k++) cyc(0, 0, 1, 1'((s >> k) & 1));
    chk("R7 first pass sum", int'(acc_q), 11);
    cyc(0, 1, 0, 0);
    chk("R8 rearm acc kept", int'(acc_q), 11);
    chk("R8 rearm done", int'(done_q), 0);
    for (int k = 0; k < W; k++) cyc(0, 0, 1, 0);
    chk("R7 serial B sum", int'(acc_q), (11 + s) % M);
    chk("R7 serial B carry", int'(carry_q), (11 + s) / M);
    chk("R8 second pass done", int'(done_q), 1);
  endtask

  task automatic t_priority;
    load_ops(15, 1);
    for (int k = 0; k < W; k++) cyc(0, 0, 1, 0);
    opa_in = 4'd9; opb_in = 4'd3;
    cyc(1, 1, 1, 1);
    chk("R9 load wins acc", int'(acc_q), 9);
    chk("R9 load wins carry", int'(carry_q), 0);
    chk("R9 load wins done", int'(done_q), 0);
    for (int k = 0; k < W; k++) cyc(0, 0, 1, 0);
    chk("R9 sum after load", int'(acc_q), 12);
    load_ops(15, 1);
    for (int k = 0; k < W; k++) cyc(0, 0, 1, 0);
    cyc(0, 1, 1, 0);
    chk("R9 rearm beats shift acc", int'(acc_q), 0);
    chk("R9 rearm beats shift carry", int'(carry_q), 0);
    chk("R9 rearm beats shift done", int'(done_q), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_exhaustive();
    t_gaps();
    t_freeze();
    t_serial();
    t_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule